// File: doc/BRIEF.md
# Packet-Filter Arithmetic Execution Unit

This block executes the arithmetic and logic instructions of an extended packet-filter virtual machine. Each operation arrives already decoded. It carries a 4-bit operation code, a class flag that picks the 64-bit or the 32-bit form, an operand-select bit, the current destination register value, the source register value and a 32-bit immediate. The unit computes the new destination value. A flag marks operations it cannot execute. The register file, instruction decode and memory access sit outside this block.

All the arithmetic is done in one combinational pass. The result is captured in a single output register that forms a valid/ready stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is shown on the next cycle and stays there until it is taken on a clock edge with `out_ready` high. While a result is waiting and `out_ready` is low, `in_ready` is low and the producer must hold its inputs. When `out_ready` is high, a waiting result can drain on the same edge that a new operation is accepted, so the unit keeps one operation per cycle.

The byte-order conversion operation uses two of its inputs in a different way. The operand-select bit gives the direction of the conversion, and the immediate gives the width in bits. The unit assumes a little-endian host.

Top module: `pfalu_unit`

## Requirements
- R1: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result and flag appear with `out_valid` high in the next cycle. `in_ready` is high exactly when no result is waiting or `out_ready` is high. A waiting result holds steady while `out_ready` is low.
- R2: With `in_use_reg` = 0 the second operand is `in_imm` sign-extended to 64 bits. With `in_use_reg` = 1 it is `in_src`.
- R3: When `in_wide` = 1 the operation works on all 64 bits. The codes are: 0x0 add, 0x1 subtract, 0x2 multiply (low 64 bits), 0x4 OR, 0x5 AND, 0xA XOR, 0xB move (result is the second operand).
- R4: When `in_wide` = 0, every code below 0xD works on the low 32 bits of both operands. The 32-bit result is zero-extended into bits 63:32.
- R5: Code 0x6 shifts left and code 0x7 shifts right logically. The shift amount is the second operand masked to 6 bits in the 64-bit form and to 5 bits in the 32-bit form.
- R6: Code 0xC shifts right arithmetically, filling with copies of bit 63 in the 64-bit form or bit 31 in the 32-bit form. The shift amount is masked as in R5.
- R7: Code 0x3 is unsigned division. Division by zero gives 0.
- R8: Code 0x9 is unsigned remainder. A zero divisor leaves the destination value as it was: all 64 bits in the 64-bit form, or the low 32 bits with the upper bits zeroed in the 32-bit form.
- R9: Code 0x8 gives the two's-complement negation of `in_dst`. Both `in_src` and `in_imm` are ignored.
- R10: Code 0xD with `in_wide` = 0 and `in_use_reg` = 0 converts to little-endian. It keeps the low 16, 32 or 64 bits of `in_dst`, as `in_imm` selects, and zero-extends the rest.
- R11: Code 0xD with `in_wide` = 0 and `in_use_reg` = 1 converts to big-endian. It reverses the byte order within the low 16, 32 or 64 bits of `in_dst` and zero-extends the rest.
- R12: `out_illegal` is 1 for codes 0xE and 0xF, for code 0xD with `in_wide` = 1, and for code 0xD with an `in_imm` other than 16, 32 or 64. The result is then `in_dst` unchanged. In every other case `out_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 4 | Operation code |
| in_wide | input | 1 | 1 = 64-bit form, 0 = 32-bit form |
| in_use_reg | input | 1 | Operand select, or conversion direction for code 0xD |
| in_dst | input | 64 | Current destination value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate, or conversion width for code 0xD |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | New destination value |
| out_illegal | output | 1 | Operation could not be executed |

## Verification
Two things can fall on the same clock edge: a waiting result draining to the consumer, and a new operation being captured into the same output register. The bench forces this case. It stalls `out_ready` while a second operation is already held at the input. It checks that the first result stays steady and that `in_ready` stays low. It then raises `out_ready` while the second operation is still presented. The next cycle must show the second result with `out_valid` still high, and no bubble or duplicate may appear. Random operations in a mix of forms and operand choices are then compared against a reference function written from the requirements.

// File: rtl/pfalu_pkg.sv
package pfalu_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned HLEN  = XLEN / 2;
  localparam int unsigned IMM_W = 32;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned SHW64 = $clog2(XLEN);
  localparam int unsigned SHW32 = $clog2(HLEN);

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
    OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'hA, OP_MOV  = 4'hB,
    OP_ARSH = 4'hC, OP_END  = 4'hD, OP_RSVE = 4'hE, OP_RSVF = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_LOGIC = 2'd1,
    SH_ARITH = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/pfalu_arith.sv
module pfalu_arith
  import pfalu_pkg::*;
(
  input  alu_op_e          op,
  input  logic             wide,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);
  logic [HLEN-1:0] a_lo, b_lo, r_lo;
  logic [XLEN-1:0] r_full;

  assign a_lo = a[HLEN-1:0];
  assign b_lo = b[HLEN-1:0];

  always_comb begin
    r_full = a;
    unique case (op)
      OP_ADD:  r_full = a + b;
      OP_SUB:  r_full = a - b;
      OP_MUL:  r_full = a * b;
      OP_DIV:  r_full = (b == '0) ? '0 : a / b;
      OP_MOD:  r_full = (b == '0) ? a  : a % b;
      OP_OR:   r_full = a | b;
      OP_AND:  r_full = a & b;
      OP_XOR:  r_full = a ^ b;
      OP_MOV:  r_full = b;
      OP_NEG:  r_full = '0 - a;
      default: r_full = a;
    endcase
  end

  always_comb begin
    r_lo = a_lo;
    unique case (op)
      OP_ADD:  r_lo = a_lo + b_lo;
      OP_SUB:  r_lo = a_lo - b_lo;
      OP_MUL:  r_lo = a_lo * b_lo;
      OP_DIV:  r_lo = (b_lo == '0) ? '0   : a_lo / b_lo;
      OP_MOD:  r_lo = (b_lo == '0) ? a_lo : a_lo % b_lo;
      OP_OR:   r_lo = a_lo | b_lo;
      OP_AND:  r_lo = a_lo & b_lo;
      OP_XOR:  r_lo = a_lo ^ b_lo;
      OP_MOV:  r_lo = b_lo;
      OP_NEG:  r_lo = '0 - a_lo;
      default: r_lo = a_lo;
    endcase
  end

  assign y = wide ? r_full : {{(XLEN-HLEN){1'b0}}, r_lo};
endmodule

// File: rtl/pfalu_shift.sv
module pfalu_shift
  import pfalu_pkg::*;
(
  input  shift_kind_e      kind,
  input  logic             wide,
  input  logic [XLEN-1:0]  a,
  input  logic [SHW64-1:0] amt,
  output logic [XLEN-1:0]  y
);
  logic [SHW32-1:0] amt_lo;
  logic [HLEN-1:0]  a_lo, r_lo;
  logic [XLEN-1:0]  r_full;

  assign amt_lo = amt[SHW32-1:0];
  assign a_lo   = a[HLEN-1:0];

  always_comb begin
    unique case (kind)
      SH_LEFT:  begin
        r_full = a << amt;
        r_lo   = a_lo << amt_lo;
      end
      SH_LOGIC: begin
        r_full = a >> amt;
        r_lo   = a_lo >> amt_lo;
      end
      default:  begin
        r_full = $unsigned($signed(a) >>> amt);
        r_lo   = $unsigned($signed(a_lo) >>> amt_lo);
      end
    endcase
  end

  assign y = wide ? r_full : {{(XLEN-HLEN){1'b0}}, r_lo};
endmodule

// File: rtl/pfalu_bswap.sv
module pfalu_bswap
  import pfalu_pkg::*;
(
  input  logic [XLEN-1:0]  v,
  input  logic [IMM_W-1:0] width_bits,
  input  logic             to_big,
  output logic [XLEN-1:0]  y,
  output logic             bad_width
);
  localparam int unsigned NB = XLEN / 8;

  logic [XLEN-1:0] rev_full;
  logic [HLEN-1:0] rev_half;
  logic [15:0]     rev_16;

  for (genvar g = 0; g < NB; g++) begin : g_rev_full
    assign rev_full[8*g +: 8] = v[8*(NB-1-g) +: 8];
  end
  for (genvar g = 0; g < NB/2; g++) begin : g_rev_half
    assign rev_half[8*g +: 8] = v[8*(NB/2-1-g) +: 8];
  end
  assign rev_16 = {v[7:0], v[15:8]};

  always_comb begin
    bad_width = 1'b0;
    y         = v;
    unique case (width_bits)
      32'd16:  y = to_big ? {{(XLEN-16){1'b0}}, rev_16}
                          : {{(XLEN-16){1'b0}}, v[15:0]};
      32'd32:  y = to_big ? {{(XLEN-HLEN){1'b0}}, rev_half}
                          : {{(XLEN-HLEN){1'b0}}, v[HLEN-1:0]};
      32'd64:  y = to_big ? rev_full : v;
      default: bad_width = 1'b1;
    endcase
  end
endmodule

// File: rtl/pfalu_unit.sv
module pfalu_unit
  import pfalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic             in_wide,
  input  logic             in_use_reg,
  input  logic [63:0]      in_dst,
  input  logic [63:0]      in_src,
  input  logic [31:0]      in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_result,
  output logic             out_illegal
);
  alu_op_e         op;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] arith_y, shift_y, swap_y;
  logic            swap_bad;
  shift_kind_e     sh_kind;
  logic [XLEN-1:0] next_result;
  logic            next_illegal;
  logic            accept;

  assign op     = alu_op_e'(in_op);
  assign opnd_b = in_use_reg ? in_src
                             : {{(XLEN-IMM_W){in_imm[IMM_W-1]}}, in_imm};

  always_comb begin
    unique case (op)
      OP_LSH:  sh_kind = SH_LEFT;
      OP_RSH:  sh_kind = SH_LOGIC;
      default: sh_kind = SH_ARITH;
    endcase
  end

  pfalu_arith u_arith (
    .op   (op),
    .wide (in_wide),
    .a    (in_dst),
    .b    (opnd_b),
    .y    (arith_y)
  );

  pfalu_shift u_shift (
    .kind (sh_kind),
    .wide (in_wide),
    .a    (in_dst),
    .amt  (opnd_b[SHW64-1:0]),
    .y    (shift_y)
  );

  pfalu_bswap u_bswap (
    .v          (in_dst),
    .width_bits (in_imm),
    .to_big     (in_use_reg),
    .y          (swap_y),
    .bad_width  (swap_bad)
  );

  always_comb begin
    next_illegal = 1'b0;
    next_result  = arith_y;
    unique case (op)
      OP_LSH, OP_RSH, OP_ARSH: next_result = shift_y;
      OP_END: begin
        next_illegal = in_wide | swap_bad;
        next_result  = next_illegal ? in_dst : swap_y;
      end
      OP_RSVE, OP_RSVF: begin
        next_illegal = 1'b1;
        next_result  = in_dst;
      end
      default: next_result = arith_y;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) begin
        out_result  <= next_result;
        out_illegal <= next_illegal;
      end
    end
  end
endmodule

// File: rtl/pfalu_chk.sv
module pfalu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  in_op,
  input logic        in_wide,
  input logic [63:0] in_dst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_illegal
);
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R1

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_wide && in_op < 4'hD |=> out_result[63:32] == 32'h0); // R4

  AST_NEG_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_wide && in_op == 4'h8 |=> out_result + $past(in_dst) == 64'h0); // R9

  AST_RESERVED_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op >= 4'hE |=> out_illegal); // R12

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_illegal || out_result == $past(in_dst)); // R12
endmodule

bind pfalu_unit pfalu_chk i_pfalu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_wide     (in_wide),
  .in_dst      (in_dst),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/test_pfalu_unit.sv
module test_pfalu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_wide = 1'b0;
  logic        in_use_reg = 1'b0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pfalu_unit i_pfalu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_use_reg(in_use_reg),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] op, logic wide);
    case (op)
      4'h6, 4'h7: return "R5";
      4'hC:       return "R6";
      4'h3:       return "R7";
      4'h9:       return "R8";
      4'h8:       return "R9";
      4'hD:       return "R10/R11/R12";
      4'hE, 4'hF: return "R12";
      default:    return wide ? "R3" : "R4";
    endcase
  endfunction

  // Reference computed from the requirements.
  function automatic logic [64:0] model(logic [3:0] op, logic wide, logic sel,
                                        logic [63:0] d, logic [63:0] s, logic [31:0] imm);
    logic [63:0] b, r64, r;
    logic [31:0] b32, d32, r32;
    logic        ill;
    int          nb;
    b   = sel ? s : {{32{imm[31]}}, imm};
    b32 = b[31:0];
    d32 = d[31:0];
    ill = 1'b0;
    r64 = d;
    r32 = d32;
    case (op)
      4'h0: begin r64 = d + b;  r32 = d32 + b32; end
      4'h1: begin r64 = d - b;  r32 = d32 - b32; end
      4'h2: begin r64 = d * b;  r32 = d32 * b32; end
      4'h3: begin r64 = (b == 0) ? 64'h0 : d / b; r32 = (b32 == 0) ? 32'h0 : d32 / b32; end
      4'h4: begin r64 = d | b;  r32 = d32 | b32; end
      4'h5: begin r64 = d & b;  r32 = d32 & b32; end
      4'h6: begin r64 = d << b[5:0]; r32 = d32 << b[4:0]; end
      4'h7: begin r64 = d >> b[5:0]; r32 = d32 >> b[4:0]; end
      4'h8: begin r64 = -d; r32 = -d32; end
      4'h9: begin r64 = (b == 0) ? d : d % b; r32 = (b32 == 0) ? d32 : d32 % b32; end
      4'hA: begin r64 = d ^ b;  r32 = d32 ^ b32; end
      4'hB: begin r64 = b;      r32 = b32; end
      4'hC: begin r64 = $unsigned($signed(d) >>> b[5:0]); r32 = $unsigned($signed(d32) >>> b[4:0]); end
      default: ;
    endcase
    r = wide ? r64 : {32'h0, r32};
    if (op == 4'hD) begin
      nb = (imm == 16) ? 2 : (imm == 32) ? 4 : (imm == 64) ? 8 : 0;
      if (wide || nb == 0) ill = 1'b1;
      else begin
        r = '0;
        for (int k = 0; k < 8; k++)
          if (k < nb) r[8*k +: 8] = sel ? d[8*(nb-1-k) +: 8] : d[8*k +: 8];
      end
    end
    if (op >= 4'hE) ill = 1'b1;
    if (ill) r = d;
    return {ill, r};
  endfunction

  task automatic drive(logic [3:0] op, logic wide, logic sel,
                       logic [63:0] d, logic [63:0] s, logic [31:0] imm);
    in_op = op; in_wide = wide; in_use_reg = sel;
    in_dst = d; in_src = s; in_imm = imm;
  endtask

  // One operation with the consumer always ready.
  task automatic run(string req, logic [3:0] op, logic wide, logic sel,
                     logic [63:0] d, logic [63:0] s, logic [31:0] imm);
    logic [64:0] e;
    e = model(op, wide, sel, d, s, imm);
    @(negedge clk);
    drive(op, wide, sel, d, s, imm);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {63'h0, out_valid}, 64'h1);
    chk({req, " result"}, out_result, e[63:0]);
    chk({req, " illegal"}, {63'h0, out_illegal}, {63'h0, e[64]});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [64:0] ea, eb;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", {63'h0, out_valid}, 64'h0);
    chk("R1 reset in_ready", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;

    // R2 / R3 operand select and wide ops
    run("R2 mov imm sext", 4'hB, 1'b1, 1'b0, 64'h1, 64'h5, 32'h8000_0001);
    run("R2 mov reg", 4'hB, 1'b1, 1'b1, 64'h1, 64'hDEAD_BEEF_0123_4567, 32'h7);
    run("R3 add", 4'h0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 32'h0);
    run("R3 mul", 4'h2, 1'b1, 1'b0, 64'h1_0000_0003, 64'h0, 32'hFFFF_FFFE);
    // R4 narrow
    run("R4 add32 wrap", 4'h0, 1'b0, 1'b0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h0, 32'h1);
    run("R4 mov32 imm", 4'hB, 1'b0, 1'b0, 64'h0, 64'h0, 32'hFFFF_FFF0);
    // R5 / R6 shift masking and sign fill
    run("R5 lsh64 by 64 masks to 0", 4'h6, 1'b1, 1'b0, 64'h1234, 64'h0, 32'd64);
    run("R5 rsh32 by 33 masks to 1", 4'h7, 1'b0, 1'b1, 64'hFFFF_FFFF_8000_0000, 64'd33, 32'h0);
    run("R6 arsh64", 4'hC, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 32'd63);
    run("R6 arsh32", 4'hC, 1'b0, 1'b0, 64'h0000_0000_8000_0010, 64'h0, 32'd4);
    // R7 / R8 zero divisors
    run("R7 div64 by zero", 4'h3, 1'b1, 1'b1, 64'h55, 64'h0, 32'h3);
    run("R7 div32 by low zero", 4'h3, 1'b0, 1'b1, 64'h55, 64'h1_0000_0000, 32'h0);
    run("R8 mod64 by zero", 4'h9, 1'b1, 1'b0, 64'hCAFE_0000_0000_0077, 64'h0, 32'h0);
    run("R8 mod32 by zero", 4'h9, 1'b0, 1'b0, 64'hCAFE_0000_0000_0077, 64'h0, 32'h0);
    run("R8 mod64", 4'h9, 1'b1, 1'b0, 64'd100, 64'h0, 32'd7);
    // R9 negate ignores source
    run("R9 neg64 src ignored", 4'h8, 1'b1, 1'b1, 64'h5, 64'hFFFF_0000, 32'h1234);
    run("R9 neg32", 4'h8, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h9, 32'h9);
    // R10 / R11 byte order
    run("R10 le16", 4'hD, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd16);
    run("R10 le64", 4'hD, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd64);
    run("R11 be16", 4'hD, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd16);
    run("R11 be32", 4'hD, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd32);
    run("R11 be64", 4'hD, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd64);
    // R12 illegal cases
    run("R12 end width 8", 4'hD, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd8);
    run("R12 end wide", 4'hD, 1'b1, 1'b0, 64'h99, 64'h0, 32'd16);
    run("R12 op E", 4'hE, 1'b1, 1'b1, 64'h42, 64'h1, 32'h1);
    run("R12 op F", 4'hF, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0042, 64'h1, 32'h1);

    // R1 stall, then drain and capture in the same cycle
    ea = model(4'h0, 1'b1, 1'b0, 64'd10, 64'h0, 32'd5);
    eb = model(4'h1, 1'b1, 1'b0, 64'd10, 64'h0, 32'd3);
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'h0, 1'b1, 1'b0, 64'd10, 64'h0, 32'd5);
    in_valid = 1'b1;
    @(negedge clk);
    drive(4'h1, 1'b1, 1'b0, 64'd10, 64'h0, 32'd3);
    chk("R1 stalled valid", {63'h0, out_valid}, 64'h1);
    chk("R1 stalled ready low", {63'h0, in_ready}, 64'h0);
    chk("R1 first result", out_result, ea[63:0]);
    @(negedge clk);
    chk("R1 held result", out_result, ea[63:0]);
    chk("R1 still not ready", {63'h0, in_ready}, 64'h0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 back-to-back valid", {63'h0, out_valid}, 64'h1);
    chk("R1 second result", out_result, eb[63:0]);
    @(negedge clk);
    chk("R1 drained", {63'h0, out_valid}, 64'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  op;
      logic [31:0] imm;
      logic [63:0] d, s;
      op = 4'($urandom_range(0, 15));
      d  = {$urandom, $urandom};
      s  = ($urandom_range(0, 7) == 0) ? 64'h0 : {$urandom, $urandom};
      imm = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom;
      if (op == 4'hD) begin
        case ($urandom_range(0, 3))
          0: imm = 32'd16;
          1: imm = 32'd32;
          2: imm = 32'd64;
          default: ;
        endcase
      end
      begin
        logic w, sel;
        w   = 1'($urandom);
        sel = 1'($urandom);
        if (op == 4'hD && $urandom_range(0, 3) != 0) w = 1'b0;
        run(req_of(op, w), op, w, sel, d, s, imm);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule